// File: doc/BRIEF.md
# Two-Road Signal Sequencer with Shared Pedestrian Crossing

This block runs a fixed-time junction with two vehicle signal heads and one walk/don't-walk pair that both roads share. A single step index walks an eight-step vehicle schedule. Right of way passes from one road to the other, and each road gets a red-plus-yellow warning before its green. After the eighth step the block adds a pedestrian interval. In that interval walk is steady first and then flashes, and both heads stay red. The schedule then starts again from its first step.

All timing is counted in whole seconds. A prescaler built from the clock produces the one-second tick, and `TICKS_PER_SEC` sets its rate. Every lamp output is registered. An output therefore changes one clock after the internal state that selects it.

Top module: `tl_crossing_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, only the red lamp is lit on each head. Don't-walk is on and walk is off.
- R2: A second lasts `TICKS_PER_SEC` clocks. Vehicle steps 1 to 8 last 6, 1, 4, 2, 6, 1, 4 and 2 seconds. A lamp change becomes visible exactly `s*TICKS_PER_SEC + 1` clocks after reset release, where `s` is the second at which the new step begins.
- R3: Head 1 is red in steps 1 to 5, red plus yellow in step 6, green only in step 7 and yellow only in step 8.
- R4: Head 2 is red in step 1, red plus yellow in step 2, green only in step 3, yellow only in step 4 and red in steps 5 to 8.
- R5: In a red-plus-yellow step the red and yellow lamps are both lit and green is dark.
- R6: Step 8 is followed by 4 seconds of steady walk with don't-walk dark. Both heads are red whenever walk is lit.
- R7: Steady walk is followed by 4 seconds of flashing. Walk is lit in the first and third second and dark in the second and fourth, and don't-walk stays dark throughout.
- R8: Don't-walk is lit and walk is dark in every vehicle step. Walk and don't-walk are never lit together.
- R9: The two heads never both show green or yellow at the same time.
- R10: After the flashing interval the schedule returns to step 1, so the whole pattern repeats every 34 seconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h1_red | output | 1 | Head 1 red lamp |
| h1_yel | output | 1 | Head 1 yellow lamp |
| h1_grn | output | 1 | Head 1 green lamp |
| h2_red | output | 1 | Head 2 red lamp |
| h2_yel | output | 1 | Head 2 yellow lamp |
| h2_grn | output | 1 | Head 2 green lamp |
| walk_lamp | output | 1 | Shared walk lamp |
| dont_walk_lamp | output | 1 | Shared don't-walk lamp |

## Verification
The bench watches the exact clock on which each step changes. A sequencer that is one second late, or one that loses the single clock of output registering, shows the old pattern for an extra second or an extra cycle. The one-second steps are the riskiest: a duration counter that is off by one would stretch or skip the red-plus-yellow warnings entirely. The bench also samples the flashing walk in every second of the interval, so an inverted flash phase or a stray don't-walk during flashing shows up. Finally, the bench applies reset in the middle of a run to confirm that the block returns to the all-red start and counts time again from zero.

// File: rtl/tl_pkg.sv
package tl_pkg;

  typedef struct packed {
    logic red;
    logic yellow;
    logic green;
  } head_t;

  localparam int NUM_HEADS   = 2;
  localparam int VEH_STEPS   = 8;
  localparam int PED_STEPS   = 2;
  localparam int ALL_STEPS   = VEH_STEPS + PED_STEPS;
  localparam int STEP_W      = $clog2(ALL_STEPS);
  localparam int PH_W        = $clog2(VEH_STEPS);
  localparam int SEC_W       = 3;
  localparam int WALK_STEP   = VEH_STEPS;
  localparam int FLASH_STEP  = VEH_STEPS + 1;
  localparam int WALK_SECS   = 4;
  localparam int FLASH_SECS  = 4;
  localparam int FLASH_HALF  = 1;
  localparam int HEAD_OFFSET = VEH_STEPS / 2;

  localparam head_t RED_ONLY = 3'b100;
  localparam head_t RED_AMB  = 3'b110;
  localparam head_t GRN_ONLY = 3'b001;
  localparam head_t AMB_ONLY = 3'b010;

  // Seconds spent in each step of the full cycle.
  function automatic logic [SEC_W-1:0] step_secs(input logic [STEP_W-1:0] s);
    case (s)
      STEP_W'(0), STEP_W'(4): step_secs = SEC_W'(6);
      STEP_W'(1), STEP_W'(5): step_secs = SEC_W'(1);
      STEP_W'(2), STEP_W'(6): step_secs = SEC_W'(4);
      STEP_W'(3), STEP_W'(7): step_secs = SEC_W'(2);
      STEP_W'(WALK_STEP):     step_secs = SEC_W'(WALK_SECS);
      STEP_W'(FLASH_STEP):    step_secs = SEC_W'(FLASH_SECS);
      default:                step_secs = SEC_W'(1);
    endcase
  endfunction

  // Lamp pattern of the head that takes its green late in the schedule.
  function automatic head_t lead_pattern(input logic [PH_W-1:0] ph);
    case (ph)
      PH_W'(5): lead_pattern = RED_AMB;
      PH_W'(6): lead_pattern = GRN_ONLY;
      PH_W'(7): lead_pattern = AMB_ONLY;
      default:  lead_pattern = RED_ONLY;
    endcase
  endfunction

endpackage

// File: rtl/tl_tick_gen.sv
module tl_tick_gen #(
  parameter int TICKS_PER_SEC = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CW'(1);
  end

  assign tick = (cnt_q == LAST);

  generate
    if (TICKS_PER_SEC > 1) begin : g_spacing
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R2
    end
  endgenerate

endmodule

// File: rtl/tl_step_seq.sv
module tl_step_seq
  import tl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  output logic [STEP_W-1:0] step_o,
  output logic [SEC_W-1:0]  sec_o
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(ALL_STEPS - 1);

  logic [STEP_W-1:0] step_q;
  logic [SEC_W-1:0]  sec_q;
  logic              step_done;

  assign step_done = tick && (sec_q == step_secs(step_q) - SEC_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      sec_q  <= '0;
    end else if (tick) begin
      if (step_done) begin
        sec_q  <= '0;
        step_q <= (step_q == LAST_STEP) ? '0 : step_q + STEP_W'(1);
      end else begin
        sec_q  <= sec_q + SEC_W'(1);
      end
    end
  end

  assign step_o = step_q;
  assign sec_o  = sec_q;

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(step_q) && $stable(sec_q))); // R2
  AST_SEC_BOUND: assert property (@(posedge clk) disable iff (rst)
    sec_q < step_secs(step_q)); // R2
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    step_q <= LAST_STEP); // R10
  AST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step_done && step_q == LAST_STEP) |=> (step_q == '0)); // R10

endmodule

// File: rtl/tl_lamp_decode.sv
module tl_lamp_decode
  import tl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [STEP_W-1:0]     step_i,
  input  logic [SEC_W-1:0]      sec_i,
  output head_t [NUM_HEADS-1:0] heads_o,
  output logic                  walk_o,
  output logic                  dont_o
);

  head_t [NUM_HEADS-1:0] heads_q;
  logic                  walk_q, dont_q;
  logic                  walk_d, dont_d;
  logic [SEC_W-1:0]      half_idx;
  logic                  flash_on;
  logic                  in_veh;

  assign in_veh = (step_i < STEP_W'(VEH_STEPS));

  // Each head reads the shared table at its own rotation of the schedule.
  for (genvar g = 0; g < NUM_HEADS; g++) begin : g_head
    localparam logic [PH_W-1:0] OFS = PH_W'((g * HEAD_OFFSET) % VEH_STEPS);
    logic [PH_W-1:0] ph;
    head_t           pat;

    always_comb begin
      ph  = step_i[PH_W-1:0] + OFS;
      pat = in_veh ? lead_pattern(ph) : RED_ONLY;
    end

    always_ff @(posedge clk) begin
      if (rst) heads_q[g] <= RED_ONLY;
      else     heads_q[g] <= pat;
    end
  end

  always_comb begin
    half_idx = sec_i / SEC_W'(FLASH_HALF);
    flash_on = ((half_idx & SEC_W'(1)) == '0);
    if (step_i == STEP_W'(WALK_STEP)) begin
      walk_d = 1'b1;
      dont_d = 1'b0;
    end else if (step_i == STEP_W'(FLASH_STEP)) begin
      walk_d = flash_on;
      dont_d = 1'b0;
    end else begin
      walk_d = 1'b0;
      dont_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      walk_q <= 1'b0;
      dont_q <= 1'b1;
    end else begin
      walk_q <= walk_d;
      dont_q <= dont_d;
    end
  end

  assign heads_o = heads_q;
  assign walk_o  = walk_q;
  assign dont_o  = dont_q;

  AST_NO_CONFLICT: assert property (@(posedge clk) disable iff (rst)
    !((heads_q[0].green || heads_q[0].yellow) &&
      (heads_q[1].green || heads_q[1].yellow))); // R9
  AST_PED_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(walk_q && dont_q)); // R8
  AST_PED_ALL_RED: assert property (@(posedge clk) disable iff (rst)
    walk_q |-> (heads_q[0] == RED_ONLY && heads_q[1] == RED_ONLY)); // R6
  AST_AMBER_NO_GREEN: assert property (@(posedge clk) disable iff (rst)
    (heads_q[0].yellow && heads_q[0].red) |-> !heads_q[0].green); // R5

endmodule

// File: rtl/tl_crossing_seq.sv
module tl_crossing_seq
  import tl_pkg::*;
#(
  parameter int TICKS_PER_SEC = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic h1_red,
  output logic h1_yel,
  output logic h1_grn,
  output logic h2_red,
  output logic h2_yel,
  output logic h2_grn,
  output logic walk_lamp,
  output logic dont_walk_lamp
);

  logic                  tick;
  logic [STEP_W-1:0]     step;
  logic [SEC_W-1:0]      sec;
  head_t [NUM_HEADS-1:0] heads;

  tl_tick_gen #(.TICKS_PER_SEC(TICKS_PER_SEC)) tick_i (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  tl_step_seq seq_i (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .step_o (step),
    .sec_o  (sec)
  );

  tl_lamp_decode dec_i (
    .clk     (clk),
    .rst     (rst),
    .step_i  (step),
    .sec_i   (sec),
    .heads_o (heads),
    .walk_o  (walk_lamp),
    .dont_o  (dont_walk_lamp)
  );

  assign h1_red = heads[0].red;
  assign h1_yel = heads[0].yellow;
  assign h1_grn = heads[0].green;
  assign h2_red = heads[1].red;
  assign h2_yel = heads[1].yellow;
  assign h2_grn = heads[1].green;

endmodule

// File: tb/tl_crossing_seq_tb_top.sv
module tl_crossing_seq_tb_top;

  localparam int T      = 4;
  localparam int PERIOD = 34;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic h1_red, h1_yel, h1_grn, h2_red, h2_yel, h2_grn, walk_lamp, dont_walk_lamp;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  tl_crossing_seq #(.TICKS_PER_SEC(T)) dut_i (
    .clk(clk), .rst(rst),
    .h1_red(h1_red), .h1_yel(h1_yel), .h1_grn(h1_grn),
    .h2_red(h2_red), .h2_yel(h2_yel), .h2_grn(h2_grn),
    .walk_lamp(walk_lamp), .dont_walk_lamp(dont_walk_lamp)
  );

  function automatic int dur(input int k);
    case (k)
      0, 4: return 6;
      1, 5: return 1;
      2, 6: return 4;
      3, 7: return 2;
      default: return 4;
    endcase
  endfunction

  // Expected {h1 rgy order red,yel,grn, h2 red,yel,grn, walk, dont} after n edges.
  function automatic logic [7:0] expect_at(input int n, output int step_k);
    int t, s, k;
    logic [2:0] a, b;
    logic w, d;
    t = (n == 0) ? 0 : (n - 1) / T;
    s = t % PERIOD;
    k = 0;
    while (s >= dur(k)) begin
      s = s - dur(k);
      k++;
    end
    step_k = k;
    case (k)
      5: a = 3'b110;
      6: a = 3'b001;
      7: a = 3'b010;
      default: a = 3'b100;
    endcase
    case (k)
      1: b = 3'b110;
      2: b = 3'b001;
      3: b = 3'b010;
      default: b = 3'b100;
    endcase
    if (k == 8)      begin w = 1'b1; d = 1'b0; end
    else if (k == 9) begin w = (s % 2 == 0); d = 1'b0; end
    else             begin w = 1'b0; d = 1'b1; end
    return {a, b, w, d};
  endfunction

  function automatic logic [7:0] outs();
    return {h1_red, h1_yel, h1_grn, h2_red, h2_yel, h2_grn, walk_lamp, dont_walk_lamp};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_cycles(input int count);
    logic [7:0] e, prev;
    int k, kp;
    string th1, th2, tp;
    prev = expect_at(0, kp);
    for (int n = 1; n <= count; n++) begin
      @(negedge clk);
      e = expect_at(n, k);
      th1 = (k >= 8) ? "R6" : ((k == 5) ? "R5" : "R3");
      th2 = (k >= 8) ? "R6" : ((k == 1) ? "R5" : "R4");
      tp  = (k == 8) ? "R6" : ((k == 9) ? "R7" : "R8");
      check(th1, {5'b0, outs()[7:5]}, {5'b0, e[7:5]});
      check(th2, {5'b0, outs()[4:2]}, {5'b0, e[4:2]});
      check(tp,  {6'b0, outs()[1:0]}, {6'b0, e[1:0]});
      // R9: never green/yellow on both heads
      check("R9", {7'b0, ((h1_grn | h1_yel) & (h2_grn | h2_yel))}, 8'd0);
      // R2: lamp change lands on exactly s*T+1 clocks
      if (e != prev) check("R2", outs(), e);
      // R10: pattern restarts at step 1 every 34 s
      if (n > 1 && (n - 1) % T == 0 && ((n - 1) / T) % PERIOD == 0)
        check("R10", outs(), 8'b100_100_01);
      prev = e;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", outs(), 8'b100_100_01);   // R1 during reset
    rst = 1'b0;
    check("R1", outs(), 8'b100_100_01);   // R1 first cycle after release
    run_cycles(3 * PERIOD * T + 9);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", outs(), 8'b100_100_01);   // R1 mid-run reset
    rst = 1'b0;
    check("R1", outs(), 8'b100_100_01);
    run_cycles(PERIOD * T + 5 * T);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule